// File: doc/BRIEF.md
# Dual-Mode Phase-Accumulator Pixel Clock Synthesizer

This block derives a video pixel clock from a fixed reference clock by direct digital synthesis. A 32-bit phase accumulator adds a programmed step on each accumulation cycle. The accumulator's most significant bit, taken through a register, gives a square-wave pixel clock. A one-cycle clock-enable pulse marks each rising edge of that square wave, so downstream logic in the reference domain can use it as a pixel strobe.

Software programs one 32-bit tuning word through a write port. The top bit of the word selects the mode and is never part of the step.

- **Low-jitter mode (top bit set).** The accumulator steps on every reference cycle. The output frequency is the step times f_ref divided by 2^32.
- **Compatibility mode (top bit clear).** The accumulator steps on every third reference cycle, so the output runs at one third of that rate. A small divide-by-three enable generator sets this pace.

Retuning does not disturb the phase. Any later frequency multiplication or division belongs to a separate PLL stage.

Top module: `dds_pixclk_top`

## Requirements
- R1: While reset is asserted, and at the first sampling after it, the tuning word, phase accumulator and divide counter are zero, and pix_clk and pix_ce are 0. With the reset word of zero, pix_clk stays 0.
- R2: A write (wr_en high at a rising edge) loads wr_data as the tuning word at that edge. The new word is used from the next accumulation step onward. The accumulated phase is kept, not cleared.
- R3: When tuning word bit 31 is 0, the accumulator advances only on every third reference cycle. The divide counter runs 0, 1, 2, 0, and a step occurs in the cycle where it reads 2. No two consecutive cycles both step.
- R4: When tuning word bit 31 is 1, the accumulator advances on every reference cycle, and the divide counter is held at 0.
- R5: The step added to the accumulator is {1'b0, word[30:0]}. Bit 31 never enters the sum, so the word 0x8000_0000 leaves the phase, and therefore pix_clk, unchanged.
- R6: pix_clk is the accumulator MSB delayed by one register. pix_ce is high for exactly one cycle, the first cycle in which pix_clk reads 1 after reading 0. pix_ce is never high in two consecutive cycles.
- R7: For a step S that divides 2^32, pix_ce repeats every 2^32/S reference cycles in low-jitter mode and every 3*2^32/S reference cycles in compatibility mode. pix_clk is high for half of each period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Tuning-word write strobe |
| wr_data | input | 32 | Tuning word: bit 31 is the mode, bits 30:0 are the step |
| pix_clk | output | 1 | Synthesized square-wave pixel clock |
| pix_ce | output | 1 | One-cycle pulse on each pix_clk rising edge |

## Verification
The words used are chosen to separate the two modes and the mode bit from the step.

- **Steps of 2^28, 2^29 and 2^30 with bit 31 set.** Their pulse periods of 16, 8 and 4 cycles show that the rate follows the step in low-jitter mode.
- **The 2^29 step with bit 31 clear.** Its 24-cycle period shows the divide-by-three pacing.
- **The word with only bit 31 set, and the all-zero word.** Both must leave the output frozen, which exposes any leak of the mode bit into the sum.
- **A retune in the middle of a run.** Compared cycle by cycle against an independent model of the requirements, it shows whether the phase is kept or wrongly cleared.

// File: rtl/dds_pkg.sv
package dds_pkg;
    localparam int unsigned TUNE_W  = 32;
    localparam int unsigned SLOW_DIV = 3;
endpackage

// File: rtl/dds_tune_reg.sv
module dds_tune_reg #(
    parameter int unsigned W = dds_pkg::TUNE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         fast_o,
    output logic [W-2:0] step_o
);
    typedef struct packed {
        logic [W-1:0] word;
    } tune_st_t;

    tune_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.word = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fast_o = st_q.word[W-1];
    assign step_o = st_q.word[W-2:0];

    // R2: a written word is visible the following cycle
    p_write_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> {fast_o, step_o} == $past(wr_data));
    // R2: without a write the word holds
    p_word_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({fast_o, step_o}));
endmodule

// File: rtl/dds_slow_div.sv
module dds_slow_div #(
    parameter int unsigned DIV = dds_pkg::SLOW_DIV
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_i,
    output logic en_o
);
    localparam int unsigned CW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fast_i)                st_d.cnt = '0;
        else if (st_q.cnt == LAST) st_d.cnt = '0;
        else                       st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o = !fast_i && (st_q.cnt == LAST);

    // R3: counter never leaves its range
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);
    // R3: slow-mode enables are never back to back
    p_en_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && !fast_i) |=> !en_o);
    // R4: counter parked at zero in low-jitter mode
    p_cnt_parked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fast_i |=> st_q.cnt == '0);
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int unsigned W = dds_pkg::TUNE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_en_i,
    input  logic [W-2:0] step_i,
    output logic         msb_o
);
    typedef struct packed {
        logic [W-1:0] phase;
    } acc_st_t;

    acc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_en_i) st_d.phase = st_q.phase + {1'b0, step_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign msb_o = st_q.phase[W-1];

    // R3: phase frozen on cycles without a step
    p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en_i |=> $stable(st_q.phase));
    // R5: a zero step keeps the phase even when stepping
    p_zero_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == '0) |=> $stable(st_q.phase));
endmodule

// File: rtl/dds_pixclk_top.sv
module dds_pixclk_top #(
    parameter int unsigned W   = dds_pkg::TUNE_W,
    parameter int unsigned DIV = dds_pkg::SLOW_DIV
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         pix_clk,
    output logic         pix_ce
);
    typedef struct packed {
        logic sq;
        logic ce;
    } out_st_t;

    logic         fast;
    logic [W-2:0] step;
    logic         div_en;
    logic         step_en;
    logic         msb;
    out_st_t      st_d, st_q;

    dds_tune_reg #(.W(W)) u_tune (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .fast_o(fast), .step_o(step)
    );

    dds_slow_div #(.DIV(DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .fast_i(fast), .en_o(div_en)
    );

    assign step_en = fast || div_en;

    dds_phase_acc #(.W(W)) u_acc (
        .clk(clk), .rst_n(rst_n), .step_en_i(step_en), .step_i(step),
        .msb_o(msb)
    );

    always_comb begin
        st_d    = st_q;
        st_d.sq = msb;
        st_d.ce = msb && !st_q.sq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pix_clk = st_q.sq;
    assign pix_ce  = st_q.ce;

    // R6: strobe only accompanies a high clock
    p_ce_with_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ce |-> pix_clk);
    // R6: strobe lasts a single cycle
    p_ce_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ce |=> !pix_ce);
    // R6: strobe marks a rise of pix_clk
    p_ce_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_clk) |-> pix_ce);
endmodule

// File: tb/dds_pixclk_top_tb.sv
module dds_pixclk_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        pix_clk, pix_ce;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dds_pixclk_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .pix_clk(pix_clk), .pix_ce(pix_ce)
    );

    // Reference model built from the requirements
    logic [31:0] m_word, m_phase;
    logic [1:0]  m_cnt;
    logic        m_sq, m_ce;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_word <= '0; m_phase <= '0; m_cnt <= '0; m_sq <= 1'b0; m_ce <= 1'b0;
        end else begin
            m_sq <= m_phase[31];
            m_ce <= m_phase[31] & ~m_sq;
            if (m_word[31] || m_cnt == 2'd2) m_phase <= m_phase + {1'b0, m_word[30:0]};
            m_cnt <= m_word[31] ? 2'd0 : (m_cnt == 2'd2 ? 2'd0 : m_cnt + 2'd1);
            if (wr_en) m_word <= wr_data;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_word(input logic [31:0] w);
        @(negedge clk); wr_en = 1'b1; wr_data = w;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic track(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(req, "pix_clk vs model", pix_clk, m_sq);
            check(req, "pix_ce vs model", pix_ce, m_ce);
        end
    endtask

    task automatic count_window(input string req, input int n, input int exp_ce, input int exp_hi);
        int ce_n = 0;
        int hi_n = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ce_n += pix_ce;
            hi_n += pix_clk;
        end
        check(req, "pulse count", ce_n, exp_ce);
        check(req, "high cycles", hi_n, exp_hi);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "pix_clk in reset", pix_clk, 0);
        check("R1", "pix_ce in reset", pix_ce, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "pix_clk after reset", pix_clk, 0);
        count_window("R1", 60, 0, 0);
    endtask

    task automatic t_fast();
        write_word(32'hA000_0000);              // R4: step 2^29, period 8
        track("R4", 20);
        count_window("R7", 80, 10, 40);
    endtask

    task automatic t_fast_quick();
        write_word(32'hC000_0000);              // R7: step 2^30, period 4
        track("R6", 12);
        count_window("R7", 40, 10, 20);
    endtask

    task automatic t_slow();
        write_word(32'h2000_0000);              // R3: step 2^29, period 24
        track("R3", 40);
        count_window("R7", 240, 10, 120);
    endtask

    task automatic t_mode_bit();
        logic held;
        write_word(32'h8000_0000);              // R5: mode bit alone, zero step
        @(negedge clk);
        held = pix_clk;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            check("R5", "pix_clk frozen", pix_clk, held);
            check("R5", "no pulse", pix_ce, 0);
        end
    endtask

    task automatic t_retune();
        write_word(32'h9000_0000);              // step 2^28
        track("R2", 5);
        write_word(32'hC000_0000);              // retune, phase kept
        track("R2", 30);
        write_word(32'h1000_0000);              // to slow mode mid-run
        track("R2", 60);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_fast();
        t_fast_quick();
        t_slow();
        t_mode_bit();
        t_retune();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule